// File: doc/BRIEF.md
# Floating-Point Control and Status Register

This block is the control and status register that sits beside a SIMD floating-point execution unit. It holds the rounding mode that the unit applies, two enables that trade IEEE behaviour for speed (flush tiny results to zero, treat denormal inputs as zero), six per-exception mask bits and six sticky exception flags. Software reads and writes the register through a plain single-cycle port. Every cycle the datapath can raise any mix of the six exception flags.

The block drives the current rounding mode and the two enables straight to the datapath. It also drives a pending signal that is high while any raised flag has its mask bit clear. A write that would set a reserved bit is refused: the register keeps its old contents and a fault output pulses for one cycle. A parameter selects whether the denormals-are-zero enable exists. When it does not, that bit is reserved.

Top module: `fpcsr_top`

## Requirements
- R1: After reset, rd_data_o reads 0x00001F80: all six masks are 1, and the flags, rounding field, flush-to-zero enable and denormals-are-zero enable are 0. exc_pending_o and fault_o are 0.
- R2: A legal write (wr_data_i[31:16] all zero, and bit 6 allowed) is visible on rd_data_o in the next cycle. rd_data_o[31:16] always reads zero.
- R3: round_mode_o equals bits 14:13, encoded 00 nearest-even, 01 toward minus infinity, 10 toward plus infinity, 11 toward zero. ftz_o equals bit 15 and daz_o equals bit 6.
- R4: A 1 on exc_raise_i[i] sets flag bit i in the next cycle. Index 5 is precision, 4 underflow, 3 overflow, 2 divide-by-zero, 1 denormal operand and 0 invalid. A set flag stays set while no write occurs.
- R5: Flags are cleared only by a software write that carries a 0 in that flag position. Other flags in the same write keep the written value.
- R6: When a write and exc_raise_i arrive in the same cycle, the result is the written value ORed with exc_raise_i.
- R7: exc_pending_o is high exactly when, for some i, flag bit i is 1 and mask bit i+7 is 0.
- R8: A write with any of bits 31:16 set pulses fault_o high for the following cycle and leaves bits 15:6 unchanged. exc_raise_i still ORs into the flags in that cycle.
- R9: With DAZ_OK = 0, a write that sets bit 6 pulses fault_o and is discarded. Bit 6 and daz_o then stay 0.
- R10: fault_o stays 0 after a legal write and in any cycle without a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Software write strobe |
| wr_data_i | input | 32 | Software write value |
| rd_data_o | output | 32 | Current register value |
| exc_raise_i | input | 6 | Exception flags raised by the datapath this cycle |
| round_mode_o | output | 2 | Active rounding mode |
| ftz_o | output | 1 | Flush-to-zero enable |
| daz_o | output | 1 | Denormals-are-zero enable |
| exc_pending_o | output | 1 | An unmasked exception flag is set |
| fault_o | output | 1 | One-cycle pulse after a refused write |

## Verification
The hardest case to reach is a write that lands in the same cycle as a datapath flag event. Only this case shows whether the write is applied first and the raised flags are ORed in after it, or the other way round. The stimulus drives wr_en_i together with exc_raise_i. The written value clears every flag, and the raised flag is one the write does not carry. A second instance built without the denormals-are-zero enable takes the same write stream, so one write with bit 6 set is accepted on one instance and refused on the other.

// File: rtl/fpcsr_pkg.sv
package fpcsr_pkg;
  localparam int CSR_W    = 32;
  localparam int LIVE_W   = 16;
  localparam int N_EXC    = 6;
  localparam int FLAG_LSB = 0;
  localparam int MASK_LSB = 7;
  localparam int DAZ_BIT  = 6;
  localparam int RC_LSB   = 13;
  localparam int RC_W     = 2;
  localparam int FTZ_BIT  = 15;
  localparam logic [LIVE_W-1:0] CSR_RST = 16'h1F80;

  typedef enum logic [RC_W-1:0] {
    RND_NEAREST = 2'b00,
    RND_DOWN    = 2'b01,
    RND_UP      = 2'b10,
    RND_ZERO    = 2'b11
  } rnd_e;
endpackage

// File: rtl/fpcsr_write_guard.sv
module fpcsr_write_guard
  import fpcsr_pkg::*;
#(
  parameter bit DAZ_OK = 1'b1
) (
  input  logic             wr_en_i,
  input  logic [CSR_W-1:0] wr_data_i,
  output logic             wr_ok_o,
  output logic             wr_bad_o
);
  logic upper_set, daz_set, illegal;

  assign upper_set = |wr_data_i[CSR_W-1:LIVE_W];
  assign daz_set   = DAZ_OK ? 1'b0 : wr_data_i[DAZ_BIT];
  assign illegal   = upper_set | daz_set;
  assign wr_ok_o   = wr_en_i & ~illegal;
  assign wr_bad_o  = wr_en_i & illegal;
endmodule

// File: rtl/fpcsr_state.sv
module fpcsr_state
  import fpcsr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_ok_i,
  input  logic [LIVE_W-1:0] wr_val_i,
  input  logic [N_EXC-1:0]  raise_i,
  output logic [LIVE_W-1:0] csr_q_o
);
  logic [LIVE_W-1:0] base, nxt;

  // write lands first, datapath flags merge on top
  always_comb begin
    base = wr_ok_i ? wr_val_i : csr_q_o;
    nxt  = base;
    nxt[FLAG_LSB +: N_EXC] = base[FLAG_LSB +: N_EXC] | raise_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) csr_q_o <= CSR_RST;
    else         csr_q_o <= nxt;
  end
endmodule

// File: rtl/fpcsr_pending.sv
module fpcsr_pending
  import fpcsr_pkg::*;
(
  input  logic [N_EXC-1:0] flags_i,
  input  logic [N_EXC-1:0] masks_i,
  output logic             pending_o
);
  logic [N_EXC-1:0] hit;

  for (genvar i = 0; i < N_EXC; i++) begin : g_hit
    assign hit[i] = flags_i[i] & ~masks_i[i];
  end

  assign pending_o = |hit;
endmodule

// File: rtl/fpcsr_top.sv
module fpcsr_top
  import fpcsr_pkg::*;
#(
  parameter bit DAZ_OK = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [CSR_W-1:0] wr_data_i,
  output logic [CSR_W-1:0] rd_data_o,
  input  logic [N_EXC-1:0] exc_raise_i,
  output logic [RC_W-1:0]  round_mode_o,
  output logic             ftz_o,
  output logic             daz_o,
  output logic             exc_pending_o,
  output logic             fault_o
);
  logic              wr_ok, wr_bad, fault_q;
  logic [LIVE_W-1:0] csr_q;

  fpcsr_write_guard #(.DAZ_OK(DAZ_OK)) u_guard (
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .wr_ok_o  (wr_ok),
    .wr_bad_o (wr_bad)
  );

  fpcsr_state u_state (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_ok_i (wr_ok),
    .wr_val_i(wr_data_i[LIVE_W-1:0]),
    .raise_i (exc_raise_i),
    .csr_q_o (csr_q)
  );

  fpcsr_pending u_pend (
    .flags_i  (csr_q[FLAG_LSB +: N_EXC]),
    .masks_i  (csr_q[MASK_LSB +: N_EXC]),
    .pending_o(exc_pending_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fault_q <= 1'b0;
    else         fault_q <= wr_bad;
  end

  assign fault_o      = fault_q;
  assign rd_data_o    = {{(CSR_W-LIVE_W){1'b0}}, csr_q};
  assign round_mode_o = csr_q[RC_LSB +: RC_W];
  assign ftz_o        = csr_q[FTZ_BIT];
  assign daz_o        = csr_q[DAZ_BIT];
endmodule

// File: rtl/fpcsr_chk.sv
module fpcsr_chk
  import fpcsr_pkg::*;
#(
  parameter bit DAZ_OK = 1'b1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [CSR_W-1:0] wr_data_i,
  input logic [N_EXC-1:0] exc_raise_i,
  input logic [CSR_W-1:0] rd_data_o,
  input logic             daz_o,
  input logic             exc_pending_o,
  input logic             fault_o
);
  p_upper_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[CSR_W-1:LIVE_W] == '0);

  p_legal_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[CSR_W-1:LIVE_W] == '0 && (DAZ_OK || !wr_data_i[DAZ_BIT]))
    |=> rd_data_o[LIVE_W-1:MASK_LSB-1] == $past(wr_data_i[LIVE_W-1:MASK_LSB-1]));

  p_raise_sets_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_raise_i != '0 |=> (rd_data_o[N_EXC-1:0] & $past(exc_raise_i)) == $past(exc_raise_i));

  p_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> (rd_data_o[N_EXC-1:0] & $past(rd_data_o[N_EXC-1:0])) == $past(rd_data_o[N_EXC-1:0]));

  p_pending_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_pending_o == |(rd_data_o[FLAG_LSB +: N_EXC] & ~rd_data_o[MASK_LSB +: N_EXC]));

  p_refused_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[CSR_W-1:LIVE_W] != '0)
    |=> fault_o && $stable(rd_data_o[LIVE_W-1:MASK_LSB-1]));

  p_no_daz_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !DAZ_OK |-> !daz_o);

  p_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> !fault_o);
endmodule

bind fpcsr_top fpcsr_chk #(.DAZ_OK(DAZ_OK)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .wr_data_i    (wr_data_i),
  .exc_raise_i  (exc_raise_i),
  .rd_data_o    (rd_data_o),
  .daz_o        (daz_o),
  .exc_pending_o(exc_pending_o),
  .fault_o      (fault_o)
);

// File: tb/sim_fpcsr_top.sv
module sim_fpcsr_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [5:0]  raise = '0;
  logic [31:0] rd0, rd1;
  logic [1:0]  rm0, rm1;
  logic        ftz0, ftz1, daz0, daz1, pend0, pend1, flt0, flt1;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] m0 = 16'h1F80, m1 = 16'h1F80;
  logic        ef0 = 1'b0, ef1 = 1'b0;

  always #2 clk = ~clk;

  fpcsr_top #(.DAZ_OK(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd0), .exc_raise_i(raise), .round_mode_o(rm0), .ftz_o(ftz0),
    .daz_o(daz0), .exc_pending_o(pend0), .fault_o(flt0));

  fpcsr_top #(.DAZ_OK(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd1), .exc_raise_i(raise), .round_mode_o(rm1), .ftz_o(ftz1),
    .daz_o(daz1), .exc_pending_o(pend1), .fault_o(flt1));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock: drive at negedge, update the reference, sample at the next negedge
  task automatic step(input logic wen, input logic [31:0] d, input logic [5:0] r);
    logic ok0, ok1;
    @(negedge clk);
    wr_en = wen; wr_data = d; raise = r;
    @(negedge clk);
    ok0 = wen && d[31:16] == 16'h0;
    ok1 = ok0 && !d[6];
    ef0 = wen && !ok0;
    ef1 = wen && !ok1;
    if (ok0) m0 = d[15:0];
    if (ok1) m1 = d[15:0];
    m0[5:0] = m0[5:0] | r;
    m1[5:0] = m1[5:0] | r;
    wr_en = 1'b0; wr_data = '0; raise = '0;
  endtask

  task automatic check_u0(input string req);
    check({req, " rd"}, rd0, {16'h0, m0});
    check({req, " round"}, {30'h0, rm0}, {30'h0, m0[14:13]});
    check({req, " ftz"}, {31'h0, ftz0}, {31'h0, m0[15]});
    check({req, " daz"}, {31'h0, daz0}, {31'h0, m0[6]});
    check({req, " pend"}, {31'h0, pend0}, {31'h0, |(m0[5:0] & ~m0[12:7])});
    check({req, " fault"}, {31'h0, flt0}, {31'h0, ef0});
  endtask

  task automatic t_reset_r1;
    check("R1 rd", rd0, 32'h0000_1F80);
    check("R1 pend", {31'h0, pend0}, 32'h0);
    check("R1 fault", {31'h0, flt0}, 32'h0);
    check("R1 rd u1", rd1, 32'h0000_1F80);
  endtask

  task automatic t_write_r2;
    step(1'b1, 32'h0000_5A55, 6'h0); check_u0("R2");
    step(1'b1, 32'h0000_0000, 6'h0); check_u0("R2");
    step(1'b1, 32'h0000_FFFF, 6'h0); check_u0("R2");
    check("R2 upper", {16'h0, rd0[31:16]}, 32'h0);
    check("R10 legal", {31'h0, flt0}, 32'h0);
  endtask

  task automatic t_round_r3;
    for (int rc = 0; rc < 4; rc++) begin
      step(1'b1, 32'h0000_1F80 | (rc << 13), 6'h0);
      check("R3 rc", {30'h0, rm0}, rc);
    end
    step(1'b1, 32'h0000_9F80, 6'h0); check("R3 ftz", {31'h0, ftz0}, 32'h1);
    step(1'b1, 32'h0000_1FC0, 6'h0); check("R3 daz", {31'h0, daz0}, 32'h1);
    check_u0("R3");
  endtask

  task automatic t_sticky_r4;
    step(1'b1, 32'h0000_1F80, 6'h0);
    step(1'b0, 32'h0, 6'b000001);
    step(1'b0, 32'h0, 6'b100000);
    step(1'b0, 32'h0, 6'h0);
    step(1'b0, 32'h0, 6'h0);
    check("R4 sticky", {26'h0, rd0[5:0]}, 32'h21);
    check_u0("R4");
  endtask

  task automatic t_clear_r5;
    step(1'b1, 32'h0000_1FA0, 6'h0);
    check("R5 partial", {26'h0, rd0[5:0]}, 32'h20);
    step(1'b1, 32'h0000_1F80, 6'h0);
    check("R5 all", {26'h0, rd0[5:0]}, 32'h0);
  endtask

  task automatic t_collide_r6;
    step(1'b1, 32'h0000_5F80, 6'b000100);
    check("R6 merge", rd0, 32'h0000_5F84);
    check_u0("R6");
  endtask

  task automatic t_pending_r7;
    step(1'b1, 32'h0000_1D80, 6'h0); check("R7 none", {31'h0, pend0}, 32'h0);
    step(1'b0, 32'h0, 6'b000010);    check("R7 masked", {31'h0, pend0}, 32'h0);
    step(1'b0, 32'h0, 6'b000100);    check("R7 unmasked", {31'h0, pend0}, 32'h1);
    step(1'b1, 32'h0000_1F84, 6'h0); check("R7 remask", {31'h0, pend0}, 32'h0);
    step(1'b1, 32'h0000_0F20, 6'h0); check("R7 prec", {31'h0, pend0}, 32'h1);
  endtask

  task automatic t_upper_r8;
    step(1'b1, 32'h0000_3F80, 6'h0);
    step(1'b1, 32'h0001_0000, 6'b001000);
    check("R8 fault", {31'h0, flt0}, 32'h1);
    check("R8 kept", rd0, 32'h0000_3F88);
    step(1'b1, 32'h8000_1F80, 6'h0);
    check_u0("R8");
    step(1'b0, 32'h0, 6'h0);
    check("R10 pulse", {31'h0, flt0}, 32'h0);
  endtask

  task automatic t_daz_r9;
    step(1'b1, 32'h0000_1F80, 6'h0);
    step(1'b1, 32'h0000_7FC0, 6'h0);
    check("R9 u0 accept", {31'h0, daz0}, 32'h1);
    check("R9 u0 fault", {31'h0, flt0}, 32'h0);
    check("R9 u1 fault", {31'h0, flt1}, 32'h1);
    check("R9 u1 kept", rd1, {16'h0, m1});
    check("R9 u1 daz", {31'h0, daz1}, 32'h0);
    check("R9 u1 rd", rd1, 32'h0000_1F80);
  endtask

  initial begin : watchdog
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_r1();
    t_write_r2();
    t_round_r3();
    t_sticky_r4();
    t_clear_r5();
    t_collide_r6();
    t_pending_r7();
    t_upper_r8();
    t_daz_r9();
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule